// File: doc/BRIEF.md
# Streaming Twiddle Phase Index Generator

This block sits after a radix-2^3 butterfly stage of a pipelined FFT of sub-transform size N and tells the downstream sine/cosine source which twiddle to apply to each sample. For every accepted sample it emits an integer phase index p, the twiddle angle being 2π·p/N. The stage output is organised as eight consecutive blocks of N/8 samples; within a block an inner position n4 runs from 0 to N/8-1, and each block has a fixed multiplier q. The index is p = n4·q mod N.

The multiplier q is the three-bit bit-reversal of the block number, so over one frame the blocks use q = 0, 4, 2, 6, 1, 5, 3, 7. The product is built by adding q to a running sum on each accepted sample instead of with a multiplier. The generator runs without a break across back-to-back frames, holds its place on cycles without a sample, and restarts on a start pulse. In a chain of stages one instance serves one stage position (for example N = 32768, 4096, 512 and 64 in a 32k transform), and parallel channels at the same position can share it.

Top module: `twid_phase_gen`

## Requirements
- R1: With N = 8^LOG8_N (LOG8_N >= 2), the phase index is 3·LOG8_N bits wide and equals (n4·q) mod N, where n4 is the sample's position within its block and q is the block's multiplier.
- R2: n4 is 0 for the first sample of a frame, rises by one per accepted sample, and wraps from N/8-1 to 0; each wrap moves to the next block, eight blocks per frame.
- R3: The block multiplier q is the bit-reversal of the 3-bit block number, giving q = 0, 4, 2, 6, 1, 5, 3, 7 for blocks 0 to 7.
- R4: valid_o equals valid_i of the previous cycle; a sample accepted at one rising edge has its index on phase_o after that edge.
- R5: In a cycle with valid_i low, no sample is consumed: the position does not advance, valid_o goes low after the edge and phase_o keeps its value.
- R6: start_i high together with valid_i makes that sample the first of a new frame (n4 = 0, q = 0, index 0); the following samples continue from there.
- R7: start_i high while valid_i is low has no effect; the next accepted sample continues the old sequence.
- R8: After the last sample of a frame (n4 = N/8-1, q = 7) the next accepted sample is n4 = 0 of block 0 with no start pulse.
- R9: While rst_ni is low, valid_o and phase_o are 0, and the first accepted sample after reset starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A stage output sample is present this cycle |
| start_i | input | 1 | With valid_i: this sample begins a new frame |
| phase_o | output | 3·LOG8_N | Phase index p, angle 2π·p/N |
| valid_o | output | 1 | phase_o carries the index of a sample |

## Verification
The assertions assume that valid_i and start_i are low while reset is applied and that they change only between clock edges; the bench drives them on the falling edge and holds them low through reset. They also rely on start_i being meaningful only with valid_i, which the bench exercises in both combinations. Two sizes (N = 64 and N = 512) are driven with the same stream of continuous runs, gapped runs, mid-frame restarts and stray start pulses, and every index is compared with the product computed from a sample count.

// File: rtl/twid_pkg.sv
package twid_pkg;
  localparam int unsigned BLK_W = 3;  // eight blocks per frame

  function automatic int unsigned idx_width(input int unsigned log8_n);
    return 3 * log8_n;
  endfunction
endpackage

// File: rtl/twid_bitrev.sv
module twid_bitrev #(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign out_o[i] = in_i[W-1-i];
  end
endmodule

// File: rtl/twid_pos_ctr.sv
module twid_pos_ctr
  import twid_pkg::*;
#(
  parameter int unsigned N4_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             restart_i,
  output logic [N4_W-1:0]  n4_o,
  output logic [BLK_W-1:0] blk_o,
  output logic             wrap_o
);
  logic [N4_W-1:0]  n4_q;
  logic [BLK_W-1:0] blk_q;

  // position of the sample being accepted now
  always_comb begin
    n4_o   = restart_i ? '0 : n4_q;
    blk_o  = restart_i ? '0 : blk_q;
    wrap_o = (n4_o == {N4_W{1'b1}});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n4_q  <= '0;
      blk_q <= '0;
    end else if (adv_i) begin
      n4_q <= n4_o + 1'b1;
      if (wrap_o) blk_q <= blk_o + 1'b1;
      else        blk_q <= blk_o;
    end
  end
endmodule

// File: rtl/twid_phase_acc.sv
module twid_phase_acc
  import twid_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             restart_i,
  input  logic             wrap_i,
  input  logic [BLK_W-1:0] step_i,
  output logic [IDX_W-1:0] acc_o
);
  logic [IDX_W-1:0] acc_q;
  logic [IDX_W-1:0] acc_nxt;

  always_comb begin
    acc_o = restart_i ? '0 : acc_q;
    // n4*q built by repeated addition; truncation is the mod N
    if (wrap_i) acc_nxt = '0;
    else        acc_nxt = acc_o + {{(IDX_W-BLK_W){1'b0}}, step_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (adv_i) acc_q <= acc_nxt;
  end
endmodule

// File: rtl/twid_phase_gen.sv
module twid_phase_gen
  import twid_pkg::*;
#(
  parameter int unsigned LOG8_N = 2,
  localparam int unsigned IDX_W = idx_width(LOG8_N),
  localparam int unsigned N4_W  = IDX_W - BLK_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             start_i,
  output logic [IDX_W-1:0] phase_o,
  output logic             valid_o
);
  logic             adv;
  logic             restart;
  logic [N4_W-1:0]  n4_cur;
  logic [BLK_W-1:0] blk_cur;
  logic [BLK_W-1:0] q_cur;
  logic             wrap;
  logic [IDX_W-1:0] acc_cur;

  assign adv     = valid_i;
  assign restart = valid_i & start_i;

  twid_pos_ctr #(.N4_W(N4_W)) u_pos (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .restart_i (restart),
    .n4_o      (n4_cur),
    .blk_o     (blk_cur),
    .wrap_o    (wrap)
  );

  twid_bitrev #(.W(BLK_W)) u_rev (
    .in_i  (blk_cur),
    .out_o (q_cur)
  );

  twid_phase_acc #(.IDX_W(IDX_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .restart_i (restart),
    .wrap_i    (wrap),
    .step_i    (q_cur),
    .acc_o     (acc_cur)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) phase_o <= acc_cur;
    end
  end
endmodule

// File: rtl/twid_phase_gen_chk.sv
module twid_phase_gen_chk #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned N4_W  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             start_i,
  input logic [IDX_W-1:0] phase_o,
  input logic             valid_o,
  input logic [N4_W-1:0]  n4_cur
);
  p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (valid_o == $past(valid_i)));

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(phase_o) && !valid_o));

  p_start_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && start_i) |=> (phase_o == '0));

  p_n4_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !start_i && n4_cur == {N4_W{1'b1}}) |=> (n4_cur == '0));
endmodule

bind twid_phase_gen twid_phase_gen_chk #(.IDX_W(IDX_W), .N4_W(N4_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .start_i (start_i),
  .phase_o (phase_o),
  .valid_o (valid_o),
  .n4_cur  (n4_cur)
);

// File: tb/twid_phase_gen_test.sv
module twid_phase_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int LA = 2;  // N = 64
  localparam int LB = 3;  // N = 512
  localparam int NA = 64;
  localparam int NB = 512;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic start_i = 1'b0;
  logic [3*LA-1:0] ph_a;
  logic [3*LB-1:0] ph_b;
  logic vo_a, vo_b;

  int n_run = 0;
  int n_fail = 0;
  int k_a = 0, k_b = 0;
  int last_a = 0, last_b = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twid_phase_gen #(.LOG8_N(LA)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .start_i(start_i),
    .phase_o(ph_a), .valid_o(vo_a));

  twid_phase_gen #(.LOG8_N(LB)) uut_b (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .start_i(start_i),
    .phase_o(ph_b), .valid_o(vo_b));

  function automatic int brev3(input int b);
    return ((b & 1) << 2) | (b & 2) | ((b >> 2) & 1);
  endfunction

  function automatic int ref_idx(input int k, input int n);
    int n8;
    n8 = n / 8;
    return ((k % n8) * brev3((k / n8) % 8)) % n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle of stimulus, then check the registered result
  task automatic cyc(input bit v, input bit s, input string req);
    int ea, eb;
    @(negedge clk);
    valid_i = v;
    start_i = s;
    if (v) begin
      if (s) begin k_a = 0; k_b = 0; end
      ea = ref_idx(k_a, NA);
      eb = ref_idx(k_b, NB);
      k_a++; k_b++;
    end else begin
      ea = last_a;
      eb = last_b;
    end
    @(posedge clk);
    #1;
    chk({req, "/R4 valid_o N64"}, int'(vo_a), int'(v));
    chk({req, "/R4 valid_o N512"}, int'(vo_b), int'(v));
    chk({req, " phase N64"}, int'(ph_a), ea);
    chk({req, " phase N512"}, int'(ph_b), eb);
    last_a = ea;
    last_b = eb;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    #(CLK_PERIOD * 3);
    chk("R9 valid_o N64", int'(vo_a), 0);
    chk("R9 phase N64", int'(ph_a), 0);
    chk("R9 valid_o N512", int'(vo_b), 0);
    chk("R9 phase N512", int'(ph_b), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 R2 R3 R8: two full large frames back to back, many small frames
    for (int i = 0; i < 2 * NB; i++) cyc(1'b1, 1'b0, "R1 R3 R8");

    // R5: gapped stream
    for (int i = 0; i < 300; i++) cyc((i % 3) != 1, 1'b0, "R5 R2");

    // R6: restart mid-frame, then run past the first blocks
    cyc(1'b1, 1'b1, "R6");
    for (int i = 0; i < 200; i++) cyc(1'b1, 1'b0, "R6");

    // R7: start without valid is ignored
    for (int i = 0; i < 40; i++) begin
      cyc(1'b0, 1'b1, "R7");
      cyc(1'b1, 1'b0, "R7");
      cyc(1'b1, 1'b0, "R7");
    end

    // R6 then full frame with sparse gaps, R8 wrap again
    cyc(1'b1, 1'b1, "R6");
    for (int i = 0; i < NB + 20; i++) cyc((i % 7) != 3, 1'b0, "R8 R2");

    // back-to-back starts
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, "R6");
    cyc(1'b0, 1'b0, "R5");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule